// File: doc/BRIEF.md
# Dual-Address I2C Configuration Target

This block is an I2C target that owns two configuration banks of 256 eight-bit registers each and answers on two 7-bit bus addresses, one per bank. Address 0x68 reaches the persistent bank, which models settings kept across power cycles. Address 0x69 reaches the working bank, which models the registers a clock core reads live. A bus master writes a register pointer and then a run of data bytes. It reads by issuing a repeated START and clocking bytes out until it answers NACK. The pointer steps after every byte and rolls over at the top of the bank.

A write-protect input guards the persistent bank only. Bytes sent to that bank while protection is on are still acknowledged, but they are thrown away. Reset loads the persistent bank with a fixed default image. The block then copies the persistent bank into the working bank, one entry per clock, and refuses every address until the copy is done. The bus pins are oversampled by the system clock through a synchronizer. SDA is modelled as a plain input, plus an enable that pulls the wire low.

Top module: `cfg_store_i2c`

## Requirements
- R1: The address byte carries the 7-bit address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). Address 0x68 is acknowledged and selects the persistent bank. Address 0x69 is acknowledged and selects the working bank.
- R2: Any other address is not acknowledged, and sda_oe stays low until the next START or STOP.
- R3: In a write, the byte after the address byte is taken as the register pointer. Every later byte is stored at the pointer and acknowledged.
- R4: A single pointer serves both addresses and is 0 after reset. It advances by one after every data byte, written or read, and wraps from 255 to 0.
- R5: After a repeated START with the read bit set, the target sends the byte at the pointer MSB first. It keeps sending bytes while the master acknowledges. A master NACK ends the read, and a later STOP or START is obeyed.
- R6: While wp_i is 1, data bytes addressed to the persistent bank are acknowledged but change nothing. The working bank accepts writes whatever the value of wp_i.
- R7: Reset default of the persistent bank: register 0x00 = 0x01 (output 1 driven from the reference clock), register 0x01 = 0x00 (bit 0 = 0 puts the shared pin in write-protect mode), and every other register i = bitwise NOT of i.
- R8: After reset, the working bank is filled from the persistent bank at one entry per clock, taking 256 clocks. Until the fill is done, every address is left unacknowledged and sda_oe stays low.
- R9: A write through one address never changes the other bank.
- R10: Transfers work when each SCL high and low phase lasts at least 8 system clocks. Two rates are checked: 8 clocks per phase (fast) and 40 clocks per phase (standard).
- R11: sda_oe is 0 in reset, and it only ever starts pulling low while SCL is low.
- R12: An SDA fall while SCL is high is a START and restarts address decoding, even in the middle of a byte. An SDA rise while SCL is high is a STOP and returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| wp_i | input | 1 | Write protect for the persistent bank |
| sda_oe | output | 1 | 1 pulls the SDA wire low |

## Verification
A bad pointer, a wrong bank select or a lost write stays hidden until the next read. At that read it shows as a wrong byte on SDA, 8 SCL clocks after the read address is acknowledged, or on the first byte after a pointer wrap. A fill that ends early or lands out of place shows as a wrong default the first time a working register is read after reset. A decoder stuck in a wrong state shows sooner: SDA is pulled low during a bit the master owns, or an expected acknowledge is missing. The bench checks the first of these on every clock while SCL is high.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_PTR,
    BUS_WDATA,
    BUS_ACK,
    BUS_RDATA,
    BUS_RACK,
    BUS_SKIP
  } bus_st_t;

  // SDA moved to to_level while SCL stayed high over two samples
  function automatic logic edge_under_high(input logic scl_prev, input logic scl_now,
                                           input logic sda_prev, input logic sda_now,
                                           input logic to_level);
    return scl_prev && scl_now && (sda_prev != sda_now) && (sda_now == to_level);
  endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  import cfg_store_pkg::*;

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = scl_q & ~scl_s;
  assign start_det = edge_under_high(scl_q, scl_s, sda_q, sda_s, 1'b0);
  assign stop_det  = edge_under_high(scl_q, scl_s, sda_q, sda_s, 1'b1);

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine #(
  parameter logic [6:0] DEV_PERS = 7'h68,
  parameter logic [6:0] DEV_WORK = 7'h69,
  parameter int         AW       = 8,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          ready,
  input  logic          wp_i,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          rd_work,
  output logic [AW-1:0] ptr,
  output logic          wr_req,
  output logic          wr_work,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ignoring
);
  import cfg_store_pkg::*;

  localparam int CW = $clog2(DW) + 1;

  bus_st_t       st, after_st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, tx;
  logic          sel_work, mack;
  logic          byte_full, last_bit, addr_hit, dev_is_work;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  assign byte_full   = (cnt == CW'(DW));
  assign last_bit    = (cnt == CW'(DW - 1));
  assign dev_is_work = (sh[DW-1:1] == DEV_WORK);
  assign addr_hit    = dev_is_work || (sh[DW-1:1] == DEV_PERS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= BUS_IDLE;
      after_st <= BUS_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      sel_work <= 1'b0;
      mack     <= 1'b0;
      wr_req   <= 1'b0;
      wr_work  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_det) begin
        st  <= BUS_ADDR;
        cnt <= '0;
      end else if (stop_det) begin
        st <= BUS_IDLE;
      end else begin
        case (st)
          BUS_ADDR, BUS_PTR, BUS_WDATA: begin
            if (scl_rise && !byte_full) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              cnt <= '0;
              if (st == BUS_ADDR) begin
                if (addr_hit && ready) begin
                  sel_work <= dev_is_work;
                  st       <= BUS_ACK;
                  after_st <= sh[0] ? BUS_RDATA : BUS_PTR;
                end else begin
                  st <= BUS_SKIP;
                end
              end else if (st == BUS_PTR) begin
                ptr      <= sh[AW-1:0];
                st       <= BUS_ACK;
                after_st <= BUS_WDATA;
              end else begin
                wr_req   <= sel_work | ~wp_i;
                wr_work  <= sel_work;
                wr_addr  <= ptr;
                wr_data  <= sh;
                ptr      <= ptr_step(ptr);
                st       <= BUS_ACK;
                after_st <= BUS_WDATA;
              end
            end
          end
          BUS_ACK: begin
            if (scl_fall) begin
              st  <= after_st;
              cnt <= '0;
              if (after_st == BUS_RDATA) begin
                tx  <= rd_data;
                ptr <= ptr_step(ptr);
              end
            end
          end
          BUS_RDATA: begin
            if (scl_fall) begin
              if (last_bit) begin
                st  <= BUS_RACK;
                cnt <= '0;
              end else begin
                tx  <= {tx[DW-2:0], 1'b0};
                cnt <= cnt + 1'b1;
              end
            end
          end
          BUS_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx  <= rd_data;
                ptr <= ptr_step(ptr);
                st  <= BUS_RDATA;
              end else begin
                st <= BUS_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = (st == BUS_ACK) || ((st == BUS_RDATA) && !tx[DW-1]);
  assign rd_work  = sel_work;
  assign ignoring = (st == BUS_SKIP);

endmodule

// File: rtl/cfg_bank_store.sv
module cfg_bank_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          wr_work,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_work,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          copy_busy,
  output logic          pers_we
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] pers_q [DEPTH];
  logic [DW-1:0] work_q [DEPTH];
  logic [AW:0]   copy_idx;
  logic [AW-1:0] copy_at;

  // power-up image of the persistent bank
  function automatic logic [DW-1:0] default_cfg(input logic [AW-1:0] idx);
    if (idx == AW'(0)) return DW'(1);   // output 1 from reference
    if (idx == AW'(1)) return '0;       // shared pin acts as write protect
    return DW'(~idx);
  endfunction

  assign copy_busy = ~copy_idx[AW];
  assign ready     = copy_idx[AW];
  assign copy_at   = copy_idx[AW-1:0];
  assign pers_we   = wr_req & ~wr_work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_idx <= '0;
    end else if (copy_busy) begin
      copy_idx <= copy_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pers_q[i] <= default_cfg(AW'(i));
    end else if (pers_we) begin
      pers_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (copy_busy) begin
      work_q[copy_at] <= pers_q[copy_at];
    end else if (wr_req && wr_work) begin
      work_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = rd_work ? work_q[rd_addr] : pers_q[rd_addr];

endmodule

// File: rtl/cfg_store_i2c.sv
module cfg_store_i2c #(
  parameter logic [6:0] DEV_PERS    = 7'h68,
  parameter logic [6:0] DEV_WORK    = 7'h69,
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ready, copy_busy, pers_we, ignoring;
  logic          rd_work, wr_req, wr_work;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] wr_data, rd_data;

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfg_i2c_engine #(.DEV_PERS(DEV_PERS), .DEV_WORK(DEV_WORK), .AW(AW), .DW(DW)) eng_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det), .ready(ready),
    .wp_i(wp_i), .rd_data(rd_data), .sda_oe(sda_oe), .rd_work(rd_work),
    .ptr(ptr), .wr_req(wr_req), .wr_work(wr_work), .wr_addr(wr_addr),
    .wr_data(wr_data), .ignoring(ignoring)
  );

  cfg_bank_store #(.AW(AW), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_work(wr_work),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_work(rd_work), .rd_addr(ptr),
    .rd_data(rd_data), .ready(ready), .copy_busy(copy_busy), .pers_we(pers_we)
  );

endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          copy_busy,
  input logic          ready,
  input logic          pers_we,
  input logic          wp_i,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr,
  input logic          ignoring
);
  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_busy |-> !sda_oe);

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pers_we |-> !wp_i);

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (wr_addr == '1)) |-> (ptr == '0));

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  // R11
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

bind cfg_store_i2c cfg_store_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .copy_busy(copy_busy), .ready(ready), .pers_we(pers_we), .wp_i(wp_i),
  .wr_req(wr_req), .wr_addr(wr_addr), .ptr(ptr), .ignoring(ignoring)
);

// File: tb/cfg_store_i2c_tb.sv
module cfg_store_i2c_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] A_PERS = 7'h68;
  localparam logic [6:0] A_WORK = 7'h69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  wire  sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int   q_clk = 4;
  int   checks = 0;
  int   fails = 0;
  int   drive_viol = 0;
  bit   allow = 1'b0;

  logic [7:0] pers_m [256];
  logic [7:0] work_m [256];
  logic [7:0] ptr_m;
  logic [7:0] dq [$];

  cfg_store_i2c dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .wp_i(wp), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // the target may only hold SDA low in bits it owns (R11, R2)
  always @(posedge clk)
    if (rst_n && scl_m && sda_oe && !allow) drive_viol++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input int i);
    if (i == 0) return 8'h01;
    if (i == 1) return 8'h00;
    return ~8'(i);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      pers_m[i] = dflt(i);
      work_m[i] = dflt(i);
    end
    ptr_m = 8'h00;
  endtask

  task automatic wq();
    repeat (q_clk) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic s);
    wq(); sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_line; wq(); scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(v[i], s);
    allow = 1'b1;
    bit_x(1'b1, s);
    allow = 1'b0;
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    logic s;
    allow = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, s);
      v = {v[6:0], s};
    end
    allow = 1'b0;
    bit_x(~give_ack, s);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, output int n_ack);
    logic k;
    n_ack = 0;
    i2c_start();
    wbyte({a, 1'b0}, k); n_ack += int'(k);
    wbyte(p, k);         n_ack += int'(k);
    foreach (dq[i]) begin
      wbyte(dq[i], k); n_ack += int'(k);
    end
    i2c_stop();
    if (a == A_PERS || a == A_WORK) begin
      ptr_m = p;
      foreach (dq[i]) begin
        if (a == A_WORK) work_m[ptr_m] = dq[i];
        else if (!wp) pers_m[ptr_m] = dq[i];
        ptr_m = ptr_m + 8'd1;
      end
    end
  endtask

  task automatic rd_txn(input logic [6:0] a, input bit setp, input logic [7:0] p,
                        input int n, input string tag);
    logic k;
    logic [7:0] v, e;
    if (setp) begin
      i2c_start();
      wbyte({a, 1'b0}, k);
      wbyte(p, k);
      ptr_m = p;
    end
    i2c_start();
    wbyte({a, 1'b1}, k);
    chk(k == 1'b1, {tag, " read address ack"}, 32'(k), 1);
    for (int j = 0; j < n; j++) begin
      rbyte(j != n - 1, v);
      e = (a == A_WORK) ? work_m[ptr_m] : pers_m[ptr_m];
      chk(v == e, tag, 32'(v), 32'(e));
      ptr_m = ptr_m + 8'd1;
    end
    i2c_stop();
  endtask

  initial begin
    int n;
    logic k, s;
    logic [7:0] v;
    model_reset();
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 reset sda_oe", 32'(sda_oe), 0);
    rst_n = 1'b1;

    // R8: the fill is still running, so the address is refused
    i2c_start();
    wbyte({A_WORK, 1'b0}, k);
    chk(k == 1'b0, "R8 nack during fill", 32'(k), 0);
    i2c_stop();
    repeat (300) @(negedge clk);

    // R7 persistent defaults, R8 working copy
    rd_txn(A_PERS, 1, 8'h00, 2, "R7 persistent default");
    rd_txn(A_WORK, 1, 8'h00, 2, "R8 working copy of defaults");
    rd_txn(A_WORK, 1, 8'h80, 1, "R8 copy deep entry");

    // R3 R4 write a run to the working bank, R9 persistent untouched
    dq = '{8'hA1, 8'hB2, 8'hC3};
    wr_txn(A_WORK, 8'h10, n);
    chk(n == 5, "R3 write acks", 32'(n), 5);
    rd_txn(A_WORK, 1, 8'h10, 3, "R3 R4 readback");
    rd_txn(A_PERS, 1, 8'h10, 3, "R9 persistent unchanged");

    // R1 persistent write with protection off, R9 working untouched
    dq = '{8'h3C, 8'h4D};
    wr_txn(A_PERS, 8'h20, n);
    chk(n == 4, "R1 persistent acks", 32'(n), 4);
    rd_txn(A_PERS, 1, 8'h20, 2, "R1 persistent readback");
    rd_txn(A_WORK, 1, 8'h20, 2, "R9 working unchanged");

    // R6 protection on
    wp = 1'b1;
    dq = '{8'h55};
    wr_txn(A_PERS, 8'h20, n);
    chk(n == 3, "R6 protected bytes still acked", 32'(n), 3);
    rd_txn(A_PERS, 1, 8'h20, 1, "R6 protected write discarded");
    dq = '{8'h66};
    wr_txn(A_WORK, 8'h21, n);
    rd_txn(A_WORK, 1, 8'h21, 1, "R6 working writable under protect");
    wp = 1'b0;

    // R4 wrap on write and on read
    dq = '{8'h11, 8'h22};
    wr_txn(A_WORK, 8'hFF, n);
    rd_txn(A_WORK, 1, 8'hFE, 3, "R4 wrap");

    // R4 R5 continue reading without a new pointer
    rd_txn(A_WORK, 0, 8'h00, 2, "R5 continue from pointer");

    // R2 foreign addresses
    dq = '{8'h99};
    wr_txn(7'h50, 8'h10, n);
    chk(n == 0, "R2 foreign address 0x50", 32'(n), 0);
    wr_txn(7'h6A, 8'h10, n);
    chk(n == 0, "R2 foreign address 0x6A", 32'(n), 0);
    rd_txn(A_WORK, 1, 8'h10, 1, "R2 bank untouched by foreign write");

    // R10 standard-rate transfer
    q_clk = 20;
    dq = '{8'h5A, 8'hA5};
    wr_txn(A_WORK, 8'h40, n);
    chk(n == 4, "R10 slow acks", 32'(n), 4);
    rd_txn(A_WORK, 1, 8'h40, 2, "R10 slow readback");
    q_clk = 4;

    // R12 START in the middle of a data byte aborts it
    i2c_start();
    wbyte({A_WORK, 1'b0}, k);
    wbyte(8'h30, k);
    bit_x(1'b1, s); bit_x(1'b0, s); bit_x(1'b1, s);
    i2c_start();
    wbyte({A_WORK, 1'b1}, k);
    chk(k == 1'b1, "R12 restart address ack", 32'(k), 1);
    rbyte(1'b0, v);
    chk(v == work_m[8'h30], "R12 aborted byte not stored", 32'(v), 32'(work_m[8'h30]));
    i2c_stop();
    ptr_m = 8'h31;
    rd_txn(A_WORK, 0, 8'h00, 1, "R12 pointer after restart");

    // second reset: defaults and copy return, pointer back to 0
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    model_reset();
    rd_txn(A_WORK, 0, 8'h00, 1, "R4 pointer zero after reset");
    rd_txn(A_WORK, 1, 8'h10, 1, "R8 working restored");
    rd_txn(A_PERS, 1, 8'h20, 1, "R7 persistent reloaded");

    chk(drive_viol == 0, "R11 R2 no drive in master bits", 32'(drive_viol), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule